// File: doc/BRIEF.md
# Multilevel Carrier-Disposition PWM Modulator

This block produces the level command for an odd-level voltage-source inverter. It compares a signed reference sample with a stack of triangular carriers, one carrier per band. The NLEV−1 carriers sit in equal bands that run from −H to +H band heights, where H = (NLEV−1)/2. Every carrier comes from one shared up/down counter. A two-bit disposition input sets the relative phase of the carriers: all in phase, split at zero, or alternating from band to band.

The reference is a signed fraction. A modulation-index input scales it to carrier units. The period input sets the carrier slope, and so the frequency ratio against the reference. The output is a signed level code equal to the number of carriers the reference exceeds, less H. The index, the disposition and the period are taken into use only at a carrier peak, so a band never changes shape halfway through a slope. The mapping of the level code to the switches of a given topology is outside this block.

Top module: `mlpwm_modulator`

## Requirements
- R1: While `rst` is high on a clock edge, `lvl_o` is 0 after that edge. That edge also loads the active period, disposition and index from the inputs, and restarts the counter at 0 counting upward.
- R2: The carrier count c rises by one each cycle from 0 to P and then falls to 0, and it repeats. A change of direction holds no extra cycle, so one carrier period lasts 2·P cycles. P is the active period, and a `per_i` value of 0 is used as 1.
- R3: Band k (k = 0 at the bottom, k = 0..NLEV−2) has a carrier value of (k−H)·P + c when its carrier is upright, and (k−H)·P + P − c when it is inverted. The carrier therefore stays inside [(k−H)·P, (k−H+1)·P].
- R4: Disposition code 0 (all in phase): every band is upright.
- R5: Disposition code 1 (split at zero): bands with k ≥ H are upright and bands with k < H are inverted.
- R6: Disposition code 2 (alternating): band k is upright when k+H is even and inverted when it is odd, so neighbouring bands are always in opposition.
- R7: The scaled reference is floor(ref·mi·H·P / 2^(RW−1+MF)). Here `ref_i` is read as a two's-complement integer, and `mi` is the active index, an unsigned value with MF fraction bits (256 means 1.0 by default).
- R8: At each clock edge, `lvl_o` takes the count of bands whose carrier is strictly less than the scaled reference, minus H. The count is computed from the state and the `ref_i` value present before that edge.
- R9: A change of `mode_i`, `mi_i` or `per_i` has no effect on `lvl_o` until the edge at the end of a peak cycle (upward and c = P). From the cycle after that edge the new values apply, and the count continues downward from the new P − 1.
- R10: Disposition code 3 behaves exactly like code 0.
- R11: `lvl_o` always lies in [−H, +H]. When the reference is above every carrier it saturates at +H, and when it is at or below every carrier it saturates at −H.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high; loads the configuration inputs |
| per_i | input | CW | Carrier half-period in cycles (0 is treated as 1) |
| mode_i | input | 2 | Disposition code: 0 in phase, 1 split at zero, 2 alternating, 3 as 0 |
| mi_i | input | MW | Modulation index, unsigned with MF fraction bits |
| ref_i | input | RW | Signed reference sample, a fraction of full scale |
| lvl_o | output | $clog2(NLEV)+1 | Signed level code in [−H, +H], registered |

## Verification
The hardest situation to reach from the ports is a configuration change that arrives in the middle of a carrier slope. Such a change must stay invisible until the next peak and then apply from the following cycle, in the middle of a downward slope with a new top value. The stimulus changes the disposition, the index and the period every few cycles at unrelated intervals, including the degenerate period 0. The bench model latches them only when its own counter reaches its peak. Any early or late pickup then shows up as a mismatch in the level code, which is compared on every cycle. Overmodulation with the largest index and a full-scale reference drives the output into both saturated levels.

// File: rtl/mlpwm_pkg.sv
package mlpwm_pkg;

  typedef enum logic [1:0] {
    DISP_INPHASE = 2'd0,
    DISP_SPLIT   = 2'd1,
    DISP_ALT     = 2'd2,
    DISP_SPARE   = 2'd3
  } disp_e;

  // Upright (1) or inverted (0) carrier for band k of a stack with half-count h.
  function automatic logic band_upright(input disp_e m, input int k, input int h);
    case (m)
      DISP_SPLIT: return (k >= h);
      DISP_ALT:   return (((k + h) % 2) == 0);
      default:    return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/mlpwm_tri.sv
module mlpwm_tri
  import mlpwm_pkg::*;
#(
  parameter int CW = 10,
  parameter int MW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] per_i,
  input  logic [1:0]    mode_i,
  input  logic [MW-1:0] mi_i,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] per_o,
  output disp_e         mode_o,
  output logic [MW-1:0] mi_o
);

  logic [CW-1:0] cnt_q, per_q;
  logic          up_q;
  disp_e         mode_q;
  logic [MW-1:0] mi_q;

  // named events
  logic peak, trough;
  assign peak   = up_q && (cnt_q >= per_q);
  assign trough = !up_q && (cnt_q == '0);

  function automatic logic [CW-1:0] clamp_per(input logic [CW-1:0] p);
    return (p == '0) ? CW'(1) : p;
  endfunction

  logic [CW-1:0] per_new;
  assign per_new = clamp_per(per_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      up_q   <= 1'b1;
      per_q  <= per_new;
      mode_q <= disp_e'(mode_i);
      mi_q   <= mi_i;
    end else if (peak) begin
      per_q  <= per_new;
      mode_q <= disp_e'(mode_i);
      mi_q   <= mi_i;
      cnt_q  <= per_new - CW'(1);
      up_q   <= 1'b0;
    end else if (trough) begin
      cnt_q  <= CW'(1);
      up_q   <= 1'b1;
    end else if (up_q) begin
      cnt_q  <= cnt_q + CW'(1);
    end else begin
      cnt_q  <= cnt_q - CW'(1);
    end
  end

  assign cnt_o  = cnt_q;
  assign per_o  = per_q;
  assign mode_o = mode_q;
  assign mi_o   = mi_q;

  // R2: count never leaves [0, P]
  a_r2_cnt_within: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= per_q);
  // R2: active period never zero
  a_r2_per_nonzero: assert property (@(posedge clk) disable iff (rst)
    per_q != '0);
  // R2: a peak always turns the count downward
  a_r2_peak_turns: assert property (@(posedge clk) disable iff (rst)
    peak |=> !up_q);
  // R2: a trough always turns the count upward
  a_r2_trough_turns: assert property (@(posedge clk) disable iff (rst)
    trough |=> up_q);
  // R2: away from a peak the count moves by exactly one
  a_r2_unit_step: assert property (@(posedge clk) disable iff (rst)
    !peak |=> (cnt_q == $past(cnt_q) + CW'(1)) || (cnt_q + CW'(1) == $past(cnt_q)));
  // R9: active configuration only changes after a peak
  a_r9_hold_cfg: assert property (@(posedge clk) disable iff (rst)
    !peak |=> $stable(mode_q) && $stable(mi_q) && $stable(per_q));

endmodule

// File: rtl/mlpwm_band.sv
module mlpwm_band
  import mlpwm_pkg::*;
#(
  parameter int CW   = 10,
  parameter int SW   = 16,
  parameter int HALF = 2,
  parameter int IDX  = 0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [CW-1:0]        cnt_i,
  input  logic [CW-1:0]        per_i,
  input  disp_e                mode_i,
  input  logic signed [SW-1:0] ref_i,
  output logic                 exc_o
);

  localparam int OFS = IDX - HALF;

  logic                 upright;
  logic signed [SW-1:0] car;

  assign upright = band_upright(mode_i, IDX, HALF);
  assign car = $signed(SW'(OFS * int'(per_i) +
                          (upright ? int'(cnt_i) : int'(per_i) - int'(cnt_i))));
  assign exc_o = (ref_i > car);

  // R3: carrier stays inside its own band
  a_r3_in_band: assert property (@(posedge clk) disable iff (rst)
    (int'(car) >= OFS * int'(per_i)) && (int'(car) <= (OFS + 1) * int'(per_i)));

endmodule

// File: rtl/mlpwm_modulator.sv
module mlpwm_modulator
  import mlpwm_pkg::*;
#(
  parameter int NLEV = 5,
  parameter int CW   = 10,
  parameter int MW   = 9,
  parameter int MF   = 8,
  parameter int RW   = 12,
  localparam int LW  = $clog2(NLEV) + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [CW-1:0]        per_i,
  input  logic [1:0]           mode_i,
  input  logic [MW-1:0]        mi_i,
  input  logic signed [RW-1:0] ref_i,
  output logic signed [LW-1:0] lvl_o
);

  localparam int NB    = NLEV - 1;
  localparam int HALF  = NB / 2;
  localparam int HW    = $clog2(HALF + 1);
  localparam int SW    = CW + HW + (MW - MF) + 3;
  localparam int SHIFT = RW - 1 + MF;

  logic [CW-1:0] cnt, per;
  disp_e         mode;
  logic [MW-1:0] mi;

  mlpwm_tri #(.CW(CW), .MW(MW)) u_tri (
    .clk(clk), .rst(rst), .per_i(per_i), .mode_i(mode_i), .mi_i(mi_i),
    .cnt_o(cnt), .per_o(per), .mode_o(mode), .mi_o(mi)
  );

  // reference in carrier units, rounded toward minus infinity
  function automatic logic signed [SW-1:0] scale_ref(
    input logic signed [RW-1:0] r, input logic [MW-1:0] m, input logic [CW-1:0] p);
    longint prod;
    prod = longint'(r) * longint'(m) * longint'(p) * longint'(HALF);
    return SW'(prod >>> SHIFT);
  endfunction

  logic signed [SW-1:0] ref_s;
  assign ref_s = scale_ref(ref_i, mi, per);

  logic [NB-1:0] exc;

  for (genvar k = 0; k < NB; k++) begin : g_band
    mlpwm_band #(.CW(CW), .SW(SW), .HALF(HALF), .IDX(k)) u_band (
      .clk(clk), .rst(rst), .cnt_i(cnt), .per_i(per), .mode_i(mode),
      .ref_i(ref_s), .exc_o(exc[k])
    );
  end

  function automatic logic signed [LW-1:0] to_level(input logic [NB-1:0] e);
    return LW'($countones(e) - HALF);
  endfunction

  logic signed [LW-1:0] lvl_q;
  always_ff @(posedge clk) begin
    if (rst) lvl_q <= '0;
    else     lvl_q <= to_level(exc);
  end
  assign lvl_o = lvl_q;

  // R1: reset drives the centre level
  a_r1_reset_centre: assert property (@(posedge clk)
    rst |=> lvl_o == '0);
  // R8: exceeded bands form a contiguous run from the bottom
  a_r8_thermometer: assert property (@(posedge clk) disable iff (rst)
    ((exc >> 1) & ~exc) == '0);
  // R11: level code inside [-H, +H]
  a_r11_level_range: assert property (@(posedge clk) disable iff (rst)
    (lvl_o >= -LW'(HALF)) && (lvl_o <= LW'(HALF)));

endmodule

// File: tb/test_mlpwm_modulator.sv
`timescale 1ns/1ps
module test_mlpwm_modulator;

  localparam int NLEV = 5;
  localparam int CW   = 10;
  localparam int MW   = 9;
  localparam int MF   = 8;
  localparam int RW   = 12;
  localparam int LW   = $clog2(NLEV) + 1;
  localparam int H    = (NLEV - 1) / 2;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic [CW-1:0]        per_i = 10'd6;
  logic [1:0]           mode_i = 2'd0;
  logic [MW-1:0]        mi_i = 9'd256;
  logic signed [RW-1:0] ref_i = '0;
  logic signed [LW-1:0] lvl_o;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";
  bit    chk_en = 1'b1;

  always #2.5 clk = ~clk;

  mlpwm_modulator #(.NLEV(NLEV), .CW(CW), .MW(MW), .MF(MF), .RW(RW)) i_mlpwm_modulator (
    .clk(clk), .rst(rst), .per_i(per_i), .mode_i(mode_i), .mi_i(mi_i),
    .ref_i(ref_i), .lvl_o(lvl_o)
  );

  // behavioural model
  int m_cnt, m_per, m_mode, m_mi, exp_lvl;
  bit m_up;

  function automatic int model_level(int r, int c, int p, int md, int mi);
    longint num, den, q, car;
    int n;
    bit inv;
    num = longint'(r) * mi * p * H;
    den = longint'(1) << (RW - 1 + MF);
    q = num / den;
    if (num < 0 && q * den != num) q = q - 1;
    n = 0;
    for (int k = 0; k < NLEV - 1; k++) begin
      if (md == 1)      inv = (k < H);
      else if (md == 2) inv = (((k + H) % 2) != 0);
      else              inv = 1'b0;
      car = longint'((k - H) * p) + (inv ? (p - c) : c);
      if (q > car) n++;
    end
    return n - H;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      exp_lvl = 0;
      m_cnt = 0; m_up = 1'b1;
      m_per = (per_i == 0) ? 1 : int'(per_i);
      m_mode = int'(mode_i); m_mi = int'(mi_i);
    end else begin
      exp_lvl = model_level(int'(ref_i), m_cnt, m_per, m_mode, m_mi);
      if (m_up && m_cnt >= m_per) begin
        m_per = (per_i == 0) ? 1 : int'(per_i);
        m_mode = int'(mode_i); m_mi = int'(mi_i);
        m_cnt = m_per - 1; m_up = 1'b0;
      end else if (m_up) m_cnt++;
      else if (m_cnt == 0) begin m_cnt = 1; m_up = 1'b1; end
      else m_cnt--;
    end
  end

  always @(negedge clk) begin
    if (chk_en) begin
      checks++;
      if (int'(lvl_o) != exp_lvl) begin
        errors++;
        $display("FAIL %s lvl_o actual %0d expected %0d at %0t", cur_req, lvl_o, exp_lvl, $time);
      end
    end
  end

  int phase_n = 0;

  task automatic drive_sine(int n, int amp);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ref_i = RW'($rtoi(amp * $sin(6.283185307 * phase_n / 97.0)));
      phase_n++;
    end
  endtask

  task automatic run_phase(string tag, int md, int mi, int per, int n);
    @(negedge clk);
    cur_req = tag;
    mode_i = md[1:0]; mi_i = MW'(mi); per_i = CW'(per);
    drive_sine(n, 2047);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL R1 watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lcg;
    // R1: reset state
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R3/R4/R7/R8: in-phase stack
    run_phase("R3/R4/R7/R8", 0, 230, 6, 500);
    // R5: split disposition
    run_phase("R5", 1, 256, 9, 500);
    // R6: alternating disposition
    run_phase("R6", 2, 200, 7, 500);
    // R10: spare code acts as in-phase
    run_phase("R10", 3, 256, 5, 300);
    // R2: zero period clamps to one, alternating bands
    run_phase("R2", 2, 256, 0, 200);
    run_phase("R2", 1, 180, 1, 200);
    // R9: configuration changes between peaks
    @(negedge clk);
    cur_req = "R9";
    lcg = 12345;
    for (int i = 0; i < 900; i++) begin
      @(negedge clk);
      if (i % 7 == 3) begin
        lcg = lcg * 1103515245 + 12345;
        mode_i = lcg[17:16];
        mi_i = MW'((lcg >>> 8) & 255) + 9'd64;
        per_i = CW'((lcg >>> 20) & 15);
      end
      ref_i = RW'($rtoi(2047 * $sin(6.283185307 * phase_n / 97.0)));
      phase_n++;
    end
    // R11: overmodulation and saturation
    @(negedge clk);
    cur_req = "R11";
    mode_i = 2'd2; mi_i = 9'd511; per_i = 10'd4;
    ref_i = 12'sd2047;
    repeat (20) @(negedge clk);
    checks++;
    if (int'(lvl_o) != H) begin
      errors++;
      $display("FAIL R11 positive saturation actual %0d expected %0d", lvl_o, H);
    end
    ref_i = -12'sd2048;
    repeat (20) @(negedge clk);
    checks++;
    if (int'(lvl_o) != -H) begin
      errors++;
      $display("FAIL R11 negative saturation actual %0d expected %0d", lvl_o, -H);
    end
    drive_sine(300, 2047);
    // R1: reset again mid-run
    @(negedge clk);
    cur_req = "R1";
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    run_phase("R4/R8", 0, 128, 3, 100);
    @(negedge clk);
    chk_en = 1'b0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule